// File: doc/BRIEF.md
# Cache Policy Pin Sampling Qualifier

This block sits beside a processor's bus controller and decides, clock by clock, whether the external writeback/writethrough policy pin may be latched for the bus cycle in flight. The bus controller reports each new cycle (its kind and whether it is locked) and then the data-ready and next-address strobes. The first of those strobes after the cycle start is the one sampling point of the cycle. The pin is captured there only if the cycle kind, the processor power state and the hold, backoff, reset and init inputs all allow it.

The outputs are the captured policy bit and a valid flag. Downstream cache-state logic reads the bit only while the flag is high. A cycle that ends with the flag low is handled as writethrough. No data streams through the block, so every pin is a plain level or strobe with no handshake.

Top module: `wbpol_sample`

## Requirements
- R1: While `rst` is high at a clock edge, `pol_vld` and `pol_bit` are both 0 after that edge.
- R2: At the first clock after `cyc_start` where `data_rdy` or `next_addr` is high, a qualified cycle latches `policy_in` into `pol_bit` and sets `pol_vld`, both visible after that edge. A strobe in the same clock as `cyc_start` is ignored.
- R3: Only the first strobe of a cycle is a sampling point. Later strobes leave `pol_bit` and `pol_vld` unchanged until the next `cyc_start`, and a clock with both strobes high counts once.
- R4: A clock with `cyc_start` high clears `pol_vld` after that edge, and `pol_bit` keeps its value.
- R5: `cyc_kind` and `cyc_locked` are taken in the `cyc_start` clock. Kind codes 0 (memory read), 1 (memory write) and 2 (writeback) qualify. Codes 3 (I/O read), 4 (I/O write), 5 (special), 6 (interrupt acknowledge) and 7 (reserved) do not, and a locked cycle never qualifies.
- R6: `pwr_state` is judged in the sampling clock. Code 0 (normal) and code 1 (system management) qualify. Codes 2 (shutdown), 3 (halt), 4 (stop-grant), 5 (stop-clock), 6 and 7 (reserved) block the capture.
- R7: `backoff`, `hold_ack` or `init` high in the sampling clock blocks the capture.
- R8: `addr_hold` high in the sampling clock blocks the capture only if `addr_hold` was also high in that cycle's `cyc_start` clock. A cycle that started with the hold low may still capture while the hold is high.
- R9: A blocked first strobe still uses up the cycle's sampling point, so `pol_vld` stays 0 (writethrough) until the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; also blocks capture |
| cyc_start | input | 1 | First clock of a new bus cycle |
| cyc_kind | input | 3 | Cycle kind code, taken with `cyc_start` |
| cyc_locked | input | 1 | Cycle is locked, taken with `cyc_start` |
| data_rdy | input | 1 | Data-ready strobe |
| next_addr | input | 1 | Next-address strobe |
| policy_in | input | 1 | External policy pin, 1 = writeback |
| pwr_state | input | 3 | Processor power/operating state code |
| addr_hold | input | 1 | Address hold request |
| backoff | input | 1 | Bus backoff |
| hold_ack | input | 1 | Hold acknowledge |
| init | input | 1 | Processor init |
| pol_bit | output | 1 | Captured policy bit |
| pol_vld | output | 1 | Captured bit is valid for the current cycle |

## Verification
Two of the block's functions can land in one clock. The first is a cycle start together with a strobe: the strobe must be ignored and the sampling point moved to the next strobe. The second is a rise of address hold in the cycle-start clock, which must make that cycle one that started under hold, so that a later strobe under the hold is refused. The bench drives each of these coincidences directly, with the policy pin set to opposite values on the ignored and the honoured strobe. It then compares `pol_vld` and `pol_bit` with a bench model. The model also treats both strobes in one clock as a single sampling point.

// File: rtl/wbpol_pkg.sv
package wbpol_pkg;
  localparam int KIND_W = 3;
  localparam int PWR_W  = 3;

  typedef enum logic [KIND_W-1:0] {
    K_MEM_RD  = 3'd0,
    K_MEM_WR  = 3'd1,
    K_WRBACK  = 3'd2,
    K_IO_RD   = 3'd3,
    K_IO_WR   = 3'd4,
    K_SPECIAL = 3'd5,
    K_INTACK  = 3'd6,
    K_RSVD    = 3'd7
  } kind_e;

  typedef enum logic [PWR_W-1:0] {
    P_NORMAL   = 3'd0,
    P_SMM      = 3'd1,
    P_SHUTDOWN = 3'd2,
    P_HALT     = 3'd3,
    P_STOPGNT  = 3'd4,
    P_STOPCLK  = 3'd5,
    P_RSVD6    = 3'd6,
    P_RSVD7    = 3'd7
  } pwr_e;

  // Context of the bus cycle in flight, frozen at cycle start
  typedef struct packed {
    logic armed;      // sampling point not yet reached
    logic kind_ok;    // cycle kind allows capture
    logic locked;     // locked cycle
    logic held_start; // address hold was high at cycle start
  } cyc_ctx_t;
endpackage

// File: rtl/wbpol_track.sv
module wbpol_track
  import wbpol_pkg::*;
#(
  parameter int KIND_W = 3,
  parameter logic [(1<<KIND_W)-1:0] KIND_OK_MASK = '1,
  localparam int KINDS = 1 << KIND_W
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              cyc_start,
  input  logic [KIND_W-1:0] cyc_kind,
  input  logic              cyc_locked,
  input  logic              addr_hold,
  input  logic              strobe,
  output cyc_ctx_t          ctx
);
  logic [KINDS-1:0] kind_hit;
  logic             kind_ok_now;

  // One-hot decode of the kind against the allowed mask
  for (genvar g = 0; g < KINDS; g++) begin : g_kind
    assign kind_hit[g] = (cyc_kind == KIND_W'(g)) && KIND_OK_MASK[g];
  end
  assign kind_ok_now = |kind_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctx <= '0;
    end else if (cyc_start) begin
      ctx.armed      <= 1'b1;
      ctx.kind_ok    <= kind_ok_now;
      ctx.locked     <= cyc_locked;
      ctx.held_start <= addr_hold;
    end else if (ctx.armed && strobe) begin
      ctx.armed <= 1'b0;
    end
  end
endmodule

// File: rtl/wbpol_gate.sv
module wbpol_gate
  import wbpol_pkg::*;
#(
  parameter int PWR_W = 3,
  parameter logic [(1<<PWR_W)-1:0] PWR_OK_MASK = '1,
  localparam int PWRS = 1 << PWR_W,
  localparam int NBLK = 5
)(
  input  cyc_ctx_t          ctx,
  input  logic              cyc_start,
  input  logic              strobe,
  input  logic [PWR_W-1:0]  pwr_state,
  input  logic              rst,
  input  logic              init,
  input  logic              backoff,
  input  logic              hold_ack,
  input  logic              addr_hold,
  output logic              sample_pt,
  output logic              take
);
  logic [PWRS-1:0] pwr_hit;
  logic            pwr_ok;
  logic [NBLK-1:0] blocker;

  for (genvar g = 0; g < PWRS; g++) begin : g_pwr
    assign pwr_hit[g] = (pwr_state == PWR_W'(g)) && PWR_OK_MASK[g];
  end
  assign pwr_ok = |pwr_hit;

  always_comb begin
    blocker[0] = rst;
    blocker[1] = init;
    blocker[2] = backoff;
    blocker[3] = hold_ack;
    blocker[4] = addr_hold && ctx.held_start;
  end

  // First strobe after cycle start; a strobe with cyc_start is address phase
  assign sample_pt = ctx.armed && !cyc_start && strobe;
  assign take      = sample_pt && ctx.kind_ok && !ctx.locked && pwr_ok
                     && (blocker == '0);
endmodule

// File: rtl/wbpol_latch.sv
module wbpol_latch (
  input  logic clk,
  input  logic rst,
  input  logic cyc_start,
  input  logic take,
  input  logic policy_in,
  output logic pol_bit,
  output logic pol_vld
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pol_bit <= 1'b0;
      pol_vld <= 1'b0;
    end else if (cyc_start) begin
      pol_vld <= 1'b0;
    end else if (take) begin
      pol_bit <= policy_in;
      pol_vld <= 1'b1;
    end
  end
endmodule

// File: rtl/wbpol_sample.sv
module wbpol_sample
  import wbpol_pkg::*;
#(
  parameter int KIND_W = 3,
  parameter int PWR_W  = 3,
  parameter logic [(1<<KIND_W)-1:0] KIND_OK_MASK = 8'b0000_0111,
  parameter logic [(1<<PWR_W)-1:0]  PWR_OK_MASK  = 8'b0000_0011
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              cyc_start,
  input  logic [KIND_W-1:0] cyc_kind,
  input  logic              cyc_locked,
  input  logic              data_rdy,
  input  logic              next_addr,
  input  logic              policy_in,
  input  logic [PWR_W-1:0]  pwr_state,
  input  logic              addr_hold,
  input  logic              backoff,
  input  logic              hold_ack,
  input  logic              init,
  output logic              pol_bit,
  output logic              pol_vld
);
  cyc_ctx_t ctx;
  logic     strobe;
  logic     sample_pt;
  logic     take;

  assign strobe = data_rdy || next_addr;

  wbpol_track #(.KIND_W(KIND_W), .KIND_OK_MASK(KIND_OK_MASK)) u_track (
    .clk(clk), .rst(rst), .cyc_start(cyc_start), .cyc_kind(cyc_kind),
    .cyc_locked(cyc_locked), .addr_hold(addr_hold), .strobe(strobe),
    .ctx(ctx)
  );

  wbpol_gate #(.PWR_W(PWR_W), .PWR_OK_MASK(PWR_OK_MASK)) u_gate (
    .ctx(ctx), .cyc_start(cyc_start), .strobe(strobe),
    .pwr_state(pwr_state), .rst(rst), .init(init), .backoff(backoff),
    .hold_ack(hold_ack), .addr_hold(addr_hold),
    .sample_pt(sample_pt), .take(take)
  );

  wbpol_latch u_latch (
    .clk(clk), .rst(rst), .cyc_start(cyc_start), .take(take),
    .policy_in(policy_in), .pol_bit(pol_bit), .pol_vld(pol_vld)
  );
endmodule

// File: rtl/wbpol_sample_chk.sv
module wbpol_sample_chk #(
  parameter int PWR_W = 3,
  parameter logic [(1<<PWR_W)-1:0] PWR_OK_MASK = 8'b0000_0011
)(
  input logic             clk,
  input logic             rst,
  input logic             cyc_start,
  input logic             data_rdy,
  input logic             next_addr,
  input logic             policy_in,
  input logic [PWR_W-1:0] pwr_state,
  input logic             backoff,
  input logic             hold_ack,
  input logic             init,
  input logic             pol_bit,
  input logic             pol_vld
);
  // R1
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!pol_vld && !pol_bit));

  // R2: valid rises only after a strobe and carries the pin's value
  a_r2_rise_on_strobe: assert property (@(posedge clk) disable iff (rst)
    !(data_rdy || next_addr) |=> !$rose(pol_vld));
  a_r2_bit_is_pin: assert property (@(posedge clk) disable iff (rst)
    (!pol_vld && !cyc_start && (data_rdy || next_addr)) |=>
      (!pol_vld || pol_bit == $past(policy_in)));

  // R3
  a_r3_hold_once: assert property (@(posedge clk) disable iff (rst)
    (pol_vld && !cyc_start) |=> (pol_vld && $stable(pol_bit)));

  // R4
  a_r4_start_clears: assert property (@(posedge clk) disable iff (rst)
    cyc_start |=> (!pol_vld && $stable(pol_bit)));

  // R6
  a_r6_power_block: assert property (@(posedge clk) disable iff (rst)
    !PWR_OK_MASK[pwr_state] |=> !$rose(pol_vld));

  // R7
  a_r7_blockers: assert property (@(posedge clk) disable iff (rst)
    (backoff || hold_ack || init) |=> !$rose(pol_vld));
endmodule

bind wbpol_sample wbpol_sample_chk #(.PWR_W(PWR_W), .PWR_OK_MASK(PWR_OK_MASK)) u_chk (
  .clk(clk), .rst(rst), .cyc_start(cyc_start), .data_rdy(data_rdy),
  .next_addr(next_addr), .policy_in(policy_in), .pwr_state(pwr_state),
  .backoff(backoff), .hold_ack(hold_ack), .init(init),
  .pol_bit(pol_bit), .pol_vld(pol_vld)
);

// File: tb/test_wbpol_sample.sv
`timescale 1ns/1ps
module test_wbpol_sample;
  logic       clk = 1'b0;
  logic       rst, cyc_start, cyc_locked, data_rdy, next_addr, policy_in;
  logic [2:0] cyc_kind, pwr_state;
  logic       addr_hold, backoff, hold_ack, init;
  logic       pol_bit, pol_vld;

  int n_run = 0;
  int n_fail = 0;
  int cycles = 0;
  logic mdl_bit;

  always #10 clk = ~clk; // 50 MHz

  wbpol_sample i_wbpol_sample (
    .clk(clk), .rst(rst), .cyc_start(cyc_start), .cyc_kind(cyc_kind),
    .cyc_locked(cyc_locked), .data_rdy(data_rdy), .next_addr(next_addr),
    .policy_in(policy_in), .pwr_state(pwr_state), .addr_hold(addr_hold),
    .backoff(backoff), .hold_ack(hold_ack), .init(init),
    .pol_bit(pol_bit), .pol_vld(pol_vld)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idle();
    rst = 0; cyc_start = 0; cyc_kind = 0; cyc_locked = 0; data_rdy = 0;
    next_addr = 0; policy_in = 0; pwr_state = 0; addr_hold = 0;
    backoff = 0; hold_ack = 0; init = 0;
  endtask

  task automatic begin_cyc(input logic [2:0] k, input logic lk, input logic ah);
    idle(); cyc_start = 1; cyc_kind = k; cyc_locked = lk; addr_hold = ah;
    tick();
    cyc_start = 0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_fail++;
      $display("FAIL watchdog: actual=%0d expected<=100000", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    idle(); rst = 1;
    tick(); tick();
    chk("R1 reset vld", pol_vld, 1'b0);
    chk("R1 reset bit", pol_bit, 1'b0);
    rst = 0;
    mdl_bit = 0;

    // Sweep: kind x locked x power x blockers x pin
    for (int k = 0; k < 8; k++)
      for (int lk = 0; lk < 2; lk++)
        for (int p = 0; p < 8; p++)
          for (int b = 0; b < 8; b++)
            for (int pin = 0; pin < 2; pin++) begin
              logic exp_take;
              exp_take = (k <= 2) && (lk == 0) && (p <= 1) && (b == 0);
              begin_cyc(3'(k), 1'(lk), 1'b0);
              chk("R4 start clears vld", pol_vld, 1'b0);
              chk("R4 start keeps bit", pol_bit, mdl_bit);
              // first strobe: alternate which strobe, both on some
              data_rdy  = ((k + pin) % 3) != 1;
              next_addr = ((k + pin) % 3) != 0;
              pwr_state = 3'(p);
              backoff = b[0]; hold_ack = b[1]; init = b[2];
              policy_in = 1'(pin);
              tick();
              if (exp_take) mdl_bit = 1'(pin);
              chk("R5/R6/R7 vld after sample", pol_vld, exp_take);
              chk("R2 bit after sample", pol_bit, mdl_bit);
              // second strobe, fully qualified, opposite pin
              data_rdy = 1; next_addr = 0; pwr_state = 0;
              backoff = 0; hold_ack = 0; init = 0;
              policy_in = ~1'(pin);
              tick();
              chk("R3/R9 vld after later strobe", pol_vld, exp_take);
              chk("R3 bit after later strobe", pol_bit, mdl_bit);
              idle();
            end

    // R2: strobe coinciding with cycle start is ignored
    idle(); cyc_start = 1; data_rdy = 1; policy_in = 1;
    tick();
    chk("R2 start-clock strobe ignored", pol_vld, 1'b0);
    cyc_start = 0; data_rdy = 0; next_addr = 1; policy_in = 0;
    tick();
    chk("R2 next strobe captures vld", pol_vld, 1'b1);
    chk("R2 next strobe captures bit", pol_bit, 1'b0);

    // R8: cycle began without hold, hold raised later -> capture
    begin_cyc(3'd0, 1'b0, 1'b0);
    addr_hold = 1; tick();
    chk("R8 hold raised after start, no strobe", pol_vld, 1'b0);
    data_rdy = 1; policy_in = 1; tick();
    chk("R8 pre-hold cycle captures vld", pol_vld, 1'b1);
    chk("R8 pre-hold cycle captures bit", pol_bit, 1'b1);

    // R8: hold rises in the start clock -> blocked at strobe under hold
    begin_cyc(3'd1, 1'b0, 1'b1);
    addr_hold = 1; next_addr = 1; policy_in = 0; tick();
    chk("R8 cycle started under hold blocked", pol_vld, 1'b0);
    chk("R8 bit kept when blocked", pol_bit, 1'b1);

    // R8: started under hold, hold released before strobe -> capture
    begin_cyc(3'd2, 1'b0, 1'b1);
    addr_hold = 0; data_rdy = 1; policy_in = 0; tick();
    chk("R8 hold released captures vld", pol_vld, 1'b1);
    chk("R8 hold released captures bit", pol_bit, 1'b0);

    // R1/R7: reset together with a strobe clears state
    begin_cyc(3'd0, 1'b0, 1'b0);
    data_rdy = 1; policy_in = 1; tick();
    chk("R2 capture before reset", pol_bit, 1'b1);
    rst = 1; data_rdy = 1; tick();
    chk("R1 reset mid-cycle vld", pol_vld, 1'b0);
    chk("R1 reset mid-cycle bit", pol_bit, 1'b0);
    rst = 0; data_rdy = 1; policy_in = 1; tick();
    chk("R7 no capture after reset without new cycle", pol_vld, 1'b0);

    idle(); tick();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule